// File: doc/BRIEF.md
# Auto-Stepping Memory Address Pointer

This block keeps the address pointer that memory-referencing operations use to pick a word in an associative memory array. Software can write the pointer directly. It is also written as a side effect when an operation names an absolute memory address. After each qualifying access the pointer can move up by one, move down by one or stay where it is. Two mode bits choose which.

Two events count as a qualifying access. The first is the completion of an operation whose operand is memory, addressed either through the pointer or by an absolute address. The second is a data-bus transfer that reaches the last segment of its window while memory is the persistent source or destination. The block holds a foreground copy and a background copy of the pointer. A select input names the active copy, and only that copy is loaded, stepped or presented.

A read word puts the pointer, zero-extended, in the low half and passes the caller's upper status bits through in the high half.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset every copy of the pointer reads as zero.
- R2: With `load_en` high at a clock edge, the active copy takes `load_addr`, and `addr_out` shows it after that edge.
- R3: A completed memory-referencing operation (`instr_done` and `instr_mem_ref` both high) steps the active copy by mode. Mode 2'b01 adds one, mode 2'b10 subtracts one, and modes 2'b00 and 2'b11 hold the value.
- R4: `instr_done` with `instr_mem_ref` low leaves the pointer unchanged.
- R5: `dacc_end_pulse` with `dacc_persist_mem` high steps the active copy by mode. With `dacc_persist_mem` low, the pulse leaves the pointer unchanged.
- R6: When both step triggers occur in the same cycle, the pointer steps once.
- R7: When a load and a step trigger occur in the same cycle, the load value is taken and no step is applied.
- R8: The pointer wraps modulo 2^AW in both directions: the maximum value plus one gives 0, and 0 minus one gives the maximum value (4095 for AW=12).
- R9: Loads and steps change only the copy named by `bank_sel` (0 = foreground, 1 = background). The other copy keeps its value, which shows on `addr_out` once it is selected.
- R10: `rd_word[15:0]` carries the active pointer zero-extended, and `rd_word[31:16]` equals `status_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write `load_addr` into the active copy |
| load_addr | input | AW | Value for a direct or absolute-address load |
| instr_done | input | 1 | An operation completed this cycle |
| instr_mem_ref | input | 1 | The completed operation had a memory operand |
| dacc_end_pulse | input | 1 | A data transfer hit the end-limit segment |
| dacc_persist_mem | input | 1 | Memory is the persistent source or destination |
| step_mode | input | 2 | 00 hold, 01 up, 10 down, 11 hold |
| bank_sel | input | SELW | Active copy: 0 foreground, 1 background |
| status_hi | input | 16 | Upper status bits for the read word |
| addr_out | output | AW | Active pointer value |
| rd_word | output | 32 | Read word: {status_hi, zero-extended pointer} |

## Verification
Two pairs of functions can land in the same cycle. A load can coincide with a step, and an instruction-completion step can coincide with an end-limit data step. The bench drives every combination of the four trigger inputs and the load strobe, under all four modes, from a known base value. It predicts the result arithmetically: a load value wins over everything else, and any number of triggers produces at most one step of ±1 modulo 4096. It judges the outcome on `addr_out` one edge later.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD     = 2'b00,
      STEP_UP       = 2'b01,
      STEP_DOWN     = 2'b10,
      STEP_HOLD_ALT = 2'b11
   } step_mode_e;

   localparam int unsigned RD_WORD_W = 32;
   localparam int unsigned RD_HALF_W = 16;
endpackage

// File: rtl/aptr_trigger.sv
module aptr_trigger (
   input  logic instr_done,
   input  logic instr_mem_ref,
   input  logic dacc_end_pulse,
   input  logic dacc_persist_mem,
   output logic step_fire
);
   logic from_instr;
   logic from_data;

   always_comb begin
      from_instr = instr_done & instr_mem_ref;
      from_data  = dacc_end_pulse & dacc_persist_mem;
      // Either source asks for one step; coincident requests merge
      step_fire  = from_instr | from_data;
   end
endmodule

// File: rtl/aptr_arith.sv
module aptr_arith
   import aptr_pkg::*;
#(
   parameter int unsigned AW           = 12,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [1:0]    mode,
   output logic [AW-1:0] nxt
);
   step_mode_e m;
   assign m = step_mode_e'(mode);

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder; the operand is +1, all-ones (-1) or zero
         logic [AW-1:0] delta;
         always_comb begin
            unique case (m)
               STEP_UP:   delta = AW'(1);
               STEP_DOWN: delta = {AW{1'b1}};
               default:   delta = '0;
            endcase
            nxt = cur + delta;
         end
      end else begin : g_split
         // Separate incrementer and decrementer followed by a mux
         logic [AW-1:0] up_v;
         logic [AW-1:0] dn_v;
         always_comb begin
            up_v = cur + AW'(1);
            dn_v = cur - AW'(1);
            unique case (m)
               STEP_UP:   nxt = up_v;
               STEP_DOWN: nxt = dn_v;
               default:   nxt = cur;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/aptr_bank.sv
module aptr_bank #(
   parameter int unsigned AW    = 12,
   parameter int unsigned BANKS = 2,
   parameter int unsigned SELW  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [SELW-1:0] sel,
   input  logic [AW-1:0]   wr_data,
   output logic [AW-1:0]   rd_data
);
   logic [AW-1:0] copy_q [BANKS];

   generate
      for (genvar i = 0; i < BANKS; i++) begin : g_copy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               copy_q[i] <= '0;
            end else if (wr_en && (sel == SELW'(i))) begin
               copy_q[i] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < BANKS; k++) begin
         if (sel == SELW'(k)) rd_data = copy_q[k];
      end
   end
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
   import aptr_pkg::*;
#(
   parameter int unsigned AW           = 12,
   parameter int unsigned BANKS        = 2,
   parameter bit          SHARED_ADDER = 1'b1,
   localparam int unsigned SELW        = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_en,
   input  logic [AW-1:0]        load_addr,
   input  logic                 instr_done,
   input  logic                 instr_mem_ref,
   input  logic                 dacc_end_pulse,
   input  logic                 dacc_persist_mem,
   input  logic [1:0]           step_mode,
   input  logic [SELW-1:0]      bank_sel,
   input  logic [RD_HALF_W-1:0] status_hi,
   output logic [AW-1:0]        addr_out,
   output logic [RD_WORD_W-1:0] rd_word
);
   initial begin
      if (AW < 1 || AW > RD_HALF_W)
         $error("addr_ptr_unit: AW must be within 1..%0d", RD_HALF_W);
      if (BANKS < 2)
         $error("addr_ptr_unit: at least two pointer copies are required");
   end

   logic          step_fire;
   logic [AW-1:0] cur_addr;
   logic [AW-1:0] stepped;
   logic [AW-1:0] next_addr;
   logic          wr_en;

   aptr_trigger u_trig (
      .instr_done      (instr_done),
      .instr_mem_ref   (instr_mem_ref),
      .dacc_end_pulse  (dacc_end_pulse),
      .dacc_persist_mem(dacc_persist_mem),
      .step_fire       (step_fire)
   );

   aptr_arith #(.AW(AW), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .cur (cur_addr),
      .mode(step_mode),
      .nxt (stepped)
   );

   // A load overrides any step requested in the same cycle
   always_comb begin
      wr_en     = load_en | step_fire;
      next_addr = load_en ? load_addr : stepped;
   end

   aptr_bank #(.AW(AW), .BANKS(BANKS), .SELW(SELW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .sel    (bank_sel),
      .wr_data(next_addr),
      .rd_data(cur_addr)
   );

   always_comb begin
      addr_out = cur_addr;
      rd_word  = {status_hi, {(RD_HALF_W - AW){1'b0}}, cur_addr};
   end
endmodule

module aptr_chk #(
   parameter int unsigned AW   = 12,
   parameter int unsigned SELW = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load_en,
   input logic [AW-1:0]   load_addr,
   input logic            instr_done,
   input logic            instr_mem_ref,
   input logic            dacc_end_pulse,
   input logic            dacc_persist_mem,
   input logic [1:0]      step_mode,
   input logic [SELW-1:0] bank_sel,
   input logic [15:0]     status_hi,
   input logic [AW-1:0]   addr_out,
   input logic [31:0]     rd_word
);
   logic trig;
   assign trig = (instr_done && instr_mem_ref) || (dacc_end_pulse && dacc_persist_mem);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (bank_sel != $past(bank_sel)) || (addr_out == $past(load_addr)));

   p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && trig && step_mode == 2'b01) |=>
         (bank_sel != $past(bank_sel)) || (addr_out == AW'($past(addr_out) + AW'(1))));

   p_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && trig && step_mode == 2'b10) |=>
         (bank_sel != $past(bank_sel)) || (addr_out == AW'($past(addr_out) - AW'(1))));

   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !trig) |=> (bank_sel != $past(bank_sel)) || $stable(addr_out));

   p_hold_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && (step_mode == 2'b00 || step_mode == 2'b11)) |=>
         (bank_sel != $past(bank_sel)) || $stable(addr_out));

   p_rdword_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word[31:16] == status_hi) && (rd_word[AW-1:0] == addr_out));
endmodule

bind addr_ptr_unit aptr_chk #(.AW(AW), .SELW(SELW)) u_chk (
   .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
   .instr_done(instr_done), .instr_mem_ref(instr_mem_ref),
   .dacc_end_pulse(dacc_end_pulse), .dacc_persist_mem(dacc_persist_mem),
   .step_mode(step_mode), .bank_sel(bank_sel), .status_hi(status_hi),
   .addr_out(addr_out), .rd_word(rd_word)
);

// File: tb/sim_addr_ptr_unit.sv
module sim_addr_ptr_unit;
   localparam int AW = 12;
   localparam int MASK = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic          instr_done = 1'b0;
   logic          instr_mem_ref = 1'b0;
   logic          dacc_end_pulse = 1'b0;
   logic          dacc_persist_mem = 1'b0;
   logic [1:0]    step_mode = 2'b00;
   logic [0:0]    bank_sel = 1'b0;
   logic [15:0]   status_hi = '0;
   logic [AW-1:0] addr_out;
   logic [31:0]   rd_word;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   addr_ptr_unit #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .instr_done(instr_done), .instr_mem_ref(instr_mem_ref),
      .dacc_end_pulse(dacc_end_pulse), .dacc_persist_mem(dacc_persist_mem),
      .step_mode(step_mode), .bank_sel(bank_sel), .status_hi(status_hi),
      .addr_out(addr_out), .rd_word(rd_word)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      load_en = 0; instr_done = 0; instr_mem_ref = 0;
      dacc_end_pulse = 0; dacc_persist_mem = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic load(input int v);
      load_en = 1; load_addr = AW'(v);
      tick();
   endtask

   function automatic int stepv(input int v, input int m);
      if (m == 1) return (v + 1) & MASK;
      if (m == 2) return (v - 1) & MASK;
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: both copies zero after reset
      chk("R1 fg", int'(addr_out), 0);
      bank_sel = 1; #1;
      chk("R1 bg", int'(addr_out), 0);
      bank_sel = 0;
      rst_n = 1;
      @(negedge clk);

      // Exhaustive load / up / down sweep (R2, R3, R8)
      for (int v = 0; v <= MASK; v++) begin
         load(v);
         chk("R2 load", int'(addr_out), v);
         step_mode = 2'b01; instr_done = 1; instr_mem_ref = 1; tick();
         chk("R3 up", int'(addr_out), (v + 1) & MASK);
         step_mode = 2'b10; dacc_end_pulse = 1; dacc_persist_mem = 1; tick();
         step_mode = 2'b10; instr_done = 1; instr_mem_ref = 1; tick();
         chk("R8 down", int'(addr_out), (v - 1) & MASK);
      end

      // R8 explicit boundaries
      load(MASK); step_mode = 2'b01; instr_done = 1; instr_mem_ref = 1; tick();
      chk("R8 max+1", int'(addr_out), 0);
      step_mode = 2'b10; instr_done = 1; instr_mem_ref = 1; tick();
      chk("R8 0-1", int'(addr_out), MASK);

      // Trigger / mode / load matrix (R3 R4 R5 R6 R7)
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 32; c++) begin
            int base, e;
            bit fire;
            base = 1000 + c;
            load(base);
            step_mode = 2'(m);
            instr_done = c[0]; instr_mem_ref = c[1];
            dacc_end_pulse = c[2]; dacc_persist_mem = c[3];
            load_en = c[4]; load_addr = AW'(3000 + c);
            fire = (c[0] && c[1]) || (c[2] && c[3]);
            if (c[4]) e = 3000 + c;
            else if (fire) e = stepv(base, m);
            else e = base;
            tick();
            if (c[4]) chk("R7 load wins", int'(addr_out), e);
            else if ((c[0] && c[1]) && (c[2] && c[3])) chk("R6 single step", int'(addr_out), e);
            else if (c[0] && !c[1]) chk("R4 non-mem instr", int'(addr_out), e);
            else if (c[2] && !c[3]) chk("R5 data pulse", int'(addr_out), e);
            else chk("R3 R5 matrix", int'(addr_out), e);
         end
      end

      // R9 bank isolation
      bank_sel = 1; load(7);
      bank_sel = 0; load(5);
      step_mode = 2'b01; instr_done = 1; instr_mem_ref = 1; tick();
      dacc_end_pulse = 1; dacc_persist_mem = 1; tick();
      chk("R9 fg stepped", int'(addr_out), 7);
      bank_sel = 1; #1;
      chk("R9 bg kept", int'(addr_out), 7);
      step_mode = 2'b10; instr_done = 1; instr_mem_ref = 1; tick();
      chk("R9 bg stepped", int'(addr_out), 6);
      bank_sel = 0; #1;
      chk("R9 fg kept", int'(addr_out), 7);

      // R10 read word
      for (int s = 0; s < 16; s++) begin
         status_hi = 16'(s * 4099 + 17);
         load(s * 251);
         chk("R10 high", int'(rd_word[31:16]), int'(status_hi));
         chk("R10 low", int'(rd_word[15:0]), (s * 251) & MASK);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule